// File: doc/BRIEF.md
# Decimal Index Register Address Adder

This block forms an indexed operand address. A caller presents a binary base address with a 2-bit index select. The block then walks one of three decimal index registers that live in character memory. It reads the units, tens and hundreds characters on three consecutive cycles, stepping the memory address down by one after each read. Each character's digit and zone bits are turned into a binary weight, and the weights are accumulated onto the base. The block returns the total modulo 16000 together with a one-cycle acknowledge.

Each character on the memory port is six bits wide. Bits [3:0] carry the digit code. Bit 4 is zone A and bit 5 is zone B, so the zone field in bits [5:4] reads 1 for A, 2 for B and 3 for BA. The zone bits on the units and hundreds characters let an index value go beyond 999. A zero select skips the memory walk and hands the base straight back. The caller decides when indexing applies.

Top module: `idx_addr_adder`

## Requirements
- R1: A request with sel_i of 1, 2 or 3 starts reads at address 89, 94 or 99 respectively. The block reads on three consecutive cycles with mem_rd_o high, at that address, then one lower, then two lower. It takes the units, tens and hundreds characters in that order.
- R2: In each character, bits [3:0] are the digit code and bits [5:4] are the zone. Zone value 1 is A, 2 is B and 3 is BA.
- R3: Digit codes 0 to 9 have their own value. Code 10 decodes as zero. Codes 11 to 15 decode as the code minus 10.
- R4: The units character adds its digit. Its zone adds a further 4000 for A, 8000 for B or 12000 for BA.
- R5: The tens character adds ten times its digit, and its zone bits have no effect.
- R6: The hundreds character adds one hundred times its digit. Its zone adds a further 1000 for A, 2000 for B or 3000 for BA.
- R7: For a base below 16000, sum_o equals base plus index value, reduced modulo 16000.
- R8: When indexing, ack_o is high for exactly one cycle, the cycle right after the third read. That is the fourth cycle after the clock edge that accepted the request. sum_o changes only in a cycle where ack_o is high and otherwise holds its value.
- R9: With sel_i of 0 the block makes no memory read. It raises ack_o in the cycle right after acceptance, with sum_o equal to the base.
- R10: A request seen from acceptance up to and including the acknowledge cycle is ignored. It does not change the result or the read addresses, and it produces no further acknowledge.
- R11: While reset is held low, ack_o and mem_rd_o are 0 and sum_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start request, accepted when idle |
| sel_i | input | 2 | Index select: 0 none, 1 A, 2 B, 3 BA |
| base_i | input | 14 | Binary base address, below 16000 |
| mem_rd_o | output | 1 | Character memory read strobe |
| mem_addr_o | output | 14 | Character memory read address |
| mem_data_i | input | 6 | Character read back in the same cycle |
| ack_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 14 | Indexed address, modulo 16000 |

## Verification
The three index registers are loaded with contrasting content:

- A plain value whose tens character carries a stray zone and whose units digit code lies above 10.
- A value using a units zone, a code-10 zero tens digit and a hundreds zone.
- The largest value, 15999.

Each register is added to a zero base, to bases that land exactly on 16000, and to bases that overflow past it. This separates the zone weights of each place, the digit decoding and the single wrap step. A zero-select pass and a request raised mid-walk show apart the bypass path and the busy lockout.

// File: rtl/idx_pkg.sv
package idx_pkg;

    // Sequencer states; the read states also name the place being read.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UNITS = 3'd1,
        ST_TENS  = 3'd2,
        ST_HUND  = 3'd3,
        ST_DONE  = 3'd4
    } idx_st_e;

    // Character field layout: the zone field position is decoded here.
    localparam int DIGIT_LSB = 0;
    localparam int DIGIT_W   = 4;
    localparam int ZONE_LSB  = 4;
    localparam int ZONE_W    = 2;

endpackage

// File: rtl/idx_char_dec.sv
module idx_char_dec #(
    parameter int CHAR_W = 6
) (
    input  logic [CHAR_W-1:0]              chr_i,
    output logic [idx_pkg::DIGIT_W-1:0]    val_o,
    output logic [idx_pkg::ZONE_W-1:0]     zone_o
);
    import idx_pkg::*;

    localparam logic [DIGIT_W-1:0] TEN = DIGIT_W'(10);

    logic [DIGIT_W-1:0] code;

    assign code   = chr_i[DIGIT_LSB +: DIGIT_W];
    assign zone_o = chr_i[ZONE_LSB +: ZONE_W];

    // Code 10 stands for zero; codes above fold back by ten.
    always_comb begin
        if (code >= TEN) val_o = code - TEN;
        else             val_o = code;
    end

    always_comb begin
        assert (val_o <= DIGIT_W'(9)) // AST_DIGIT_RANGE // R3
            else $error("decoded digit out of range");
    end

endmodule

// File: rtl/idx_term.sv
module idx_term #(
    parameter int SUM_W        = 15,
    parameter int UNIT_ZONE_WT = 4000,
    parameter int HUND_ZONE_WT = 1000
) (
    input  idx_pkg::idx_st_e               place_i,
    input  logic [idx_pkg::DIGIT_W-1:0]    val_i,
    input  logic [idx_pkg::ZONE_W-1:0]     zone_i,
    output logic [SUM_W-1:0]               term_o
);
    import idx_pkg::*;

    logic [SUM_W-1:0] val_w;
    logic [SUM_W-1:0] zone_w;

    assign val_w  = SUM_W'(val_i);
    assign zone_w = SUM_W'(zone_i);

    // Weight of one character by its place; tens zone carries no weight.
    always_comb begin
        case (place_i)
            ST_UNITS: term_o = zone_w * SUM_W'(UNIT_ZONE_WT) + val_w;
            ST_TENS:  term_o = val_w * SUM_W'(10);
            ST_HUND:  term_o = zone_w * SUM_W'(HUND_ZONE_WT) + val_w * SUM_W'(100);
            default:  term_o = '0;
        endcase
    end

endmodule

// File: rtl/idx_wrap.sv
module idx_wrap #(
    parameter int SUM_W  = 15,
    parameter int ADDR_W = 14,
    parameter int MOD    = 16000
) (
    input  logic [SUM_W-1:0]  raw_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Both operands stay below MOD, so one conditional subtraction suffices.
    always_comb begin
        if (raw_i >= SUM_W'(MOD)) addr_o = ADDR_W'(raw_i - SUM_W'(MOD));
        else                      addr_o = ADDR_W'(raw_i);
    end

    always_comb begin
        assert (addr_o < ADDR_W'(MOD)) // AST_WRAP_RANGE // R7
            else $error("wrapped address not below modulus");
    end

endmodule

// File: rtl/idx_addr_adder.sv
module idx_addr_adder #(
    parameter int CHAR_W   = 6,
    parameter int ADDR_W   = 14,
    parameter int MOD      = 16000,
    parameter int UNITS_A  = 89,
    parameter int UNITS_B  = 94,
    parameter int UNITS_BA = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        sel_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [CHAR_W-1:0] mem_data_i,
    output logic              ack_o,
    output logic [ADDR_W-1:0] sum_o
);
    import idx_pkg::*;

    localparam int SUM_W = $clog2(2 * MOD);

    typedef struct packed {
        idx_st_e           st;
        logic [ADDR_W-1:0] ptr;
        logic [SUM_W-1:0]  acc;
        logic [ADDR_W-1:0] res;
    } regs_t;

    regs_t q, d;

    logic [DIGIT_W-1:0] dig_val;
    logic [ZONE_W-1:0]  dig_zone;
    logic [SUM_W-1:0]   term;
    logic [SUM_W-1:0]   acc_sum;
    logic [SUM_W-1:0]   wrap_in;
    logic [ADDR_W-1:0]  wrap_out;
    logic [ADDR_W-1:0]  start_addr;

    idx_char_dec #(.CHAR_W(CHAR_W)) u_dec (
        .chr_i  (mem_data_i),
        .val_o  (dig_val),
        .zone_o (dig_zone)
    );

    idx_term #(.SUM_W(SUM_W)) u_term (
        .place_i (q.st),
        .val_i   (dig_val),
        .zone_i  (dig_zone),
        .term_o  (term)
    );

    idx_wrap #(.SUM_W(SUM_W), .ADDR_W(ADDR_W), .MOD(MOD)) u_wrap (
        .raw_i  (wrap_in),
        .addr_o (wrap_out)
    );

    assign acc_sum = q.acc + term;
    assign wrap_in = (q.st == ST_HUND) ? acc_sum : SUM_W'(base_i);

    // Units position of the selected register.
    always_comb begin
        case (sel_i)
            2'd1:    start_addr = ADDR_W'(UNITS_A);
            2'd2:    start_addr = ADDR_W'(UNITS_B);
            2'd3:    start_addr = ADDR_W'(UNITS_BA);
            default: start_addr = '0;
        endcase
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (sel_i == 2'd0) begin
                        d.res = wrap_out;
                        d.st  = ST_DONE;
                    end else begin
                        d.ptr = start_addr;
                        d.acc = SUM_W'(base_i);
                        d.st  = ST_UNITS;
                    end
                end
            end
            ST_UNITS: begin
                d.acc = acc_sum;
                d.ptr = q.ptr - ADDR_W'(1);
                d.st  = ST_TENS;
            end
            ST_TENS: begin
                d.acc = acc_sum;
                d.ptr = q.ptr - ADDR_W'(1);
                d.st  = ST_HUND;
            end
            ST_HUND: begin
                d.acc = acc_sum;
                d.res = wrap_out;
                d.st  = ST_DONE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.ptr <= '0;
            q.acc <= '0;
            q.res <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_o   = (q.st == ST_UNITS) || (q.st == ST_TENS) || (q.st == ST_HUND);
    assign mem_addr_o = q.ptr;
    assign ack_o      = (q.st == ST_DONE);
    assign sum_o      = q.res;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o) else $error("ack longer than one cycle"); // R8

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> $stable(sum_o)) else $error("sum moved without ack"); // R8

    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (sum_o < ADDR_W'(MOD))) else $error("sum not reduced"); // R7

    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) - ADDR_W'(1)))
        else $error("read address did not step down"); // R1

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> (mem_addr_o == ADDR_W'(UNITS_A) || mem_addr_o == ADDR_W'(UNITS_B)
                             || mem_addr_o == ADDR_W'(UNITS_BA)))
        else $error("walk began at a non-units address"); // R1

    AST_THREE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(mem_rd_o)) |-> ($past(mem_rd_o, 2) && $past(mem_rd_o, 3) && !$past(mem_rd_o, 4)))
        else $error("indexed ack not after exactly three reads"); // R8

endmodule

// File: tb/idx_addr_adder_bench.sv
`timescale 1ns/1ps
module idx_addr_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  sel_i = 2'd0;
    logic [13:0] base_i = '0;
    logic        mem_rd_o;
    logic [13:0] mem_addr_o;
    logic [5:0]  mem_data_i;
    logic        ack_o;
    logic [13:0] sum_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [5:0] mem [0:127];

    always #10 clk = ~clk;

    assign mem_data_i = mem[mem_addr_o[6:0]];

    idx_addr_adder u_idx_addr_adder (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .sel_i      (sel_i),
        .base_i     (base_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .mem_data_i (mem_data_i),
        .ack_o      (ack_o),
        .sum_o      (sum_o)
    );

    // {sel, base, expected}
    // A = 123 (units code 13 -> 3, tens zone B ignored): R3, R5
    // B = 4000+5 + 0 + 700+3000 = 7705 (tens code 10 -> 0): R3, R4, R6
    // BA = 12000+9 + 90 + 900+3000 = 15999: R4, R6
    localparam logic [29:0] VECS [0:8] = '{
        {2'd1, 14'd0,     14'd123},
        {2'd1, 14'd15900, 14'd23},
        {2'd2, 14'd1000,  14'd8705},
        {2'd2, 14'd8295,  14'd0},
        {2'd3, 14'd0,     14'd15999},
        {2'd3, 14'd1,     14'd0},
        {2'd3, 14'd15999, 14'd15998},
        {2'd0, 14'd4321,  14'd4321},
        {2'd0, 14'd15999, 14'd15999}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int units_of(input logic [1:0] s);
        case (s)
            2'd1: return 89;
            2'd2: return 94;
            2'd3: return 99;
            default: return 0;
        endcase
    endfunction

    // Issue a request, optionally pulse a competing one while busy.
    task automatic run(input logic [1:0] s, input logic [13:0] b, input int exp, input bit disturb);
        int lat = 0;
        int nrd = 0;
        int addrs [0:7];
        int res = -1;
        @(negedge clk);
        req_i = 1'b1; sel_i = s; base_i = b;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            if (disturb && n >= 2) begin
                req_i = 1'b1; sel_i = 2'd1; base_i = 14'd5;
            end
            if (mem_rd_o) begin
                addrs[nrd] = int'(mem_addr_o);
                nrd++;
            end
            if (ack_o) begin
                lat = n; res = int'(sum_o);
                req_i = 1'b0;
                break;
            end
            @(negedge clk);
        end
        req_i = 1'b0;
        check(res == exp, disturb ? "R10" : "R7", res, exp);
        if (s == 2'd0) begin
            check(lat == 1, "R9", lat, 1);
            check(nrd == 0, "R9", nrd, 0);
        end else begin
            check(lat == 4, "R8", lat, 4);
            check(nrd == 3, "R1", nrd, 3);
            for (int k = 0; k < 3 && k < nrd; k++)
                check(addrs[k] == units_of(s) - k, "R1", addrs[k], units_of(s) - k);
        end
        @(negedge clk);
        check(ack_o == 1'b0, "R8", int'(ack_o), 0);
        check(int'(sum_o) == exp, "R8", int'(sum_o), exp);
        if (disturb) begin
            for (int n = 0; n < 5; n++) begin
                @(negedge clk);
                check(ack_o == 1'b0 && mem_rd_o == 1'b0, "R10", int'(ack_o), 0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 6'h00;
        mem[89] = 6'h0D;   // units code 13
        mem[88] = 6'h22;   // tens 2, zone B (ignored)
        mem[87] = 6'h01;   // hundreds 1
        mem[94] = 6'h15;   // units 5, zone A
        mem[93] = 6'h0A;   // tens code 10 -> 0
        mem[92] = 6'h37;   // hundreds 7, zone BA
        mem[99] = 6'h39;   // units 9, zone BA
        mem[98] = 6'h09;
        mem[97] = 6'h39;   // hundreds 9, zone BA
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ack_o == 1'b0, "R11", int'(ack_o), 0);
        check(mem_rd_o == 1'b0, "R11", int'(mem_rd_o), 0);
        check(sum_o == 14'd0, "R11", int'(sum_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack_o == 1'b0 && mem_rd_o == 1'b0, "R11", int'(ack_o), 0);

        foreach (VECS[i])
            run(VECS[i][29:28], VECS[i][27:14], int'(VECS[i][13:0]), 1'b0);

        // Busy lockout: competing request during the walk (R10)
        run(2'd2, 14'd1000, 8705, 1'b1);

        // Zone bits alone on an all-zero register via base 0 (R2)
        mem[99] = 6'h20; mem[98] = 6'h00; mem[97] = 6'h10;
        run(2'd3, 14'd0, 9000, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule